// File: doc/BRIEF.md
# Quasi-Bidirectional Port Controller

This block controls an 8-line port that has no direction register. Any line can be an output or an input. The core writes an output latch, and for every line the block produces three pad controls. The first is a weak pull-up enable, which is always on. The second is a strong pull-down enable, which stays on while the latched bit is 0. The third is a short strong pull-up pulse, which fires whenever a 1 is written to the bit. A line latched at 1 is held high only by the weak device, so an outside driver can pull it low. That is how the line works as an input. Two instances of the block behave the same way.

The core reaches the latch through a valid/ready command channel. A command either loads a new value or applies an AND or OR mask to the current latch contents. Masks act on the latch, never on the pins. Reads use a second valid/ready request channel. Each accepted read returns, one cycle later, the raw pin levels captured at the accepting clock edge. Input is not held anywhere between reads. Neither channel ever applies back-pressure: both ready outputs are tied high, so a request is taken in every cycle where its valid is high. The read response has no ready input. The response valid is high for exactly one cycle and the consumer must take the data in that cycle.

Top module: `qbd_port`

## Requirements
- R1: During and after reset, the latch reads as all ones. Weak pull-up is on for every line, and no strong pull-up or strong pull-down is active.
- R2: An accepted command changes the latch at the accepting clock edge. The latch then holds its value until the next accepted command.
- R3: Command codes on `cmd_op` are 2'b00 load `cmd_data`, 2'b01 AND the latch with `cmd_data`, and 2'b10 OR the latch with `cmd_data`. Code 2'b11 is reserved: it changes neither the latch nor the pulses.
- R4: `weak_pu_o` is all ones in every cycle.
- R5: `strong_pd_o[i]` is high exactly when latch bit i is 0. It changes in the cycle after the command is accepted.
- R6: For every bit whose new latch value is 1 after an accepted command, `strong_pu_o` is high for exactly PULSE_CYCLES cycles (at least 1), starting the cycle after acceptance. This includes bits that were already 1. A new command restarts the count. A bit whose new value is 0 has its pulse cleared at once.
- R7: For any bit, `strong_pu_o` and `strong_pd_o` are never high in the same cycle.
- R8: An accepted read raises `rd_vld_o` for one cycle on the next cycle. `rd_data_o` then carries the values on `pin_i` at the accepting edge.
- R9: `cmd_ready_o` and `rd_ready_o` are always high. `rd_vld_o` is low in every cycle that does not follow an accepted read.
- R10: A mask command uses the latch contents even when a pin is held low externally. For example, OR with 0 leaves a latched 1 at 1 while the line is pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command accepted (always high) |
| cmd_op_i | input | 2 | Command code: 00 load, 01 AND, 10 OR, 11 reserved |
| cmd_data_i | input | WIDTH | Load value or mask |
| rd_valid_i | input | 1 | Read request |
| rd_ready_o | output | 1 | Read request accepted (always high) |
| rd_vld_o | output | 1 | Read data valid, one cycle |
| rd_data_o | output | WIDTH | Pin levels sampled at the request edge |
| pin_i | input | WIDTH | Present logic level of each line |
| weak_pu_o | output | WIDTH | Weak pull-up enable per line |
| strong_pu_o | output | WIDTH | Strong pull-up pulse per line |
| strong_pd_o | output | WIDTH | Strong pull-down enable per line |

## Verification
A corrupted latch shows up on `strong_pd_o` in the cycle after the faulty command, and every later mask command carries the error forward. A pulse counter that loads or decrements wrongly makes `strong_pu_o` too long, too short or missing. That is visible within PULSE_CYCLES+1 cycles of the write, and a counter left running over a pull-down also breaks R7. A read path that returns the latch instead of the pins only shows up when a line latched at 1 is pulled low externally. The bench therefore drives that case on purpose and compares `rd_data_o` in the cycle after each request.

// File: rtl/qbd_pkg.sv
package qbd_pkg;
  typedef enum logic [1:0] {
    QOP_LOAD = 2'b00,
    QOP_AND  = 2'b01,
    QOP_OR   = 2'b10,
    QOP_RSVD = 2'b11
  } qop_e;
endpackage

// File: rtl/qbd_latch_ctl.sv
module qbd_latch_ctl
  import qbd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [WIDTH-1:0] cmd_data,
  output logic             fire,
  output logic [WIDTH-1:0] next_val,
  output logic [WIDTH-1:0] latch_q
);
  qop_e op_e;
  logic started;

  assign op_e = qop_e'(cmd_op);

  always_comb begin
    fire     = 1'b0;
    next_val = latch_q;
    if (cmd_valid) begin
      case (op_e)
        QOP_LOAD: begin fire = 1'b1; next_val = cmd_data;           end
        QOP_AND:  begin fire = 1'b1; next_val = latch_q & cmd_data; end
        QOP_OR:   begin fire = 1'b1; next_val = latch_q | cmd_data; end
        default:  begin fire = 1'b0; next_val = latch_q;            end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '1;
      started <= 1'b0;
    end else begin
      started <= 1'b1;
      if (fire) latch_q <= next_val;
    end
  end

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !fire) |=> $stable(latch_q));
  // R3
  rsvd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b11) |-> !fire);
endmodule

// File: rtl/qbd_pulse_gen.sv
module qbd_pulse_gen #(
  parameter int WIDTH        = 8,
  parameter int PULSE_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [WIDTH-1:0] next_val,
  output logic [WIDTH-1:0] strong_pu
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_V = CW'(PULSE_CYCLES);

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (fire)            cnt <= next_val[i] ? LOAD_V : '0;
        else if (cnt != '0)       cnt <= cnt - 1'b1;
      end
      assign strong_pu[i] = (cnt != '0);
    end
  endgenerate

  // R6
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (strong_pu == $past(next_val)));
  // R6
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && strong_pu == '0) |=> (strong_pu == '0));
endmodule

// File: rtl/qbd_read_unit.sv
module qbd_read_unit #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_valid,
  input  logic [WIDTH-1:0] pin_i,
  output logic             rd_vld,
  output logic [WIDTH-1:0] rd_data
);
  logic started;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
      started <= 1'b0;
    end else begin
      started <= 1'b1;
      rd_vld  <= rd_valid;
      if (rd_valid) rd_data <= pin_i;
    end
  end

  // R8
  read_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && rd_valid) |=> (rd_vld && rd_data == $past(pin_i)));
  // R9
  rsp_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !rd_valid) |=> !rd_vld);
endmodule

// File: rtl/qbd_port.sv
module qbd_port #(
  parameter int WIDTH        = 8,
  parameter int PULSE_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [1:0]       cmd_op_i,
  input  logic [WIDTH-1:0] cmd_data_i,
  input  logic             rd_valid_i,
  output logic             rd_ready_o,
  output logic             rd_vld_o,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] weak_pu_o,
  output logic [WIDTH-1:0] strong_pu_o,
  output logic [WIDTH-1:0] strong_pd_o
);
  logic             fire;
  logic [WIDTH-1:0] next_val;
  logic [WIDTH-1:0] latch_q;

  assign cmd_ready_o = 1'b1;
  assign rd_ready_o  = 1'b1;

  qbd_latch_ctl #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid_i), .cmd_op(cmd_op_i),
    .cmd_data(cmd_data_i), .fire(fire), .next_val(next_val), .latch_q(latch_q)
  );

  qbd_pulse_gen #(.WIDTH(WIDTH), .PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .next_val(next_val),
    .strong_pu(strong_pu_o)
  );

  qbd_read_unit #(.WIDTH(WIDTH)) u_read (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid_i), .pin_i(pin_i),
    .rd_vld(rd_vld_o), .rd_data(rd_data_o)
  );

  assign strong_pd_o = ~latch_q;
  assign weak_pu_o   = '1;

  // R7
  no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strong_pu_o & strong_pd_o) == '0);
  // R4
  weak_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    weak_pu_o == {WIDTH{1'b1}});
endmodule

// File: tb/tb_qbd_port.sv
module tb_qbd_port;
  timeunit 1ns; timeprecision 1ps;
  localparam int W  = 8;
  localparam int TP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [W-1:0] cmd_data = '0;
  logic rd_valid = 1'b0;
  logic [W-1:0] ext_low = '0;
  logic cmd_ready, rd_ready, rd_vld;
  logic [W-1:0] rd_data, pin, weak_pu, strong_pu, strong_pd;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // resolved pad: external low or strong pull-down wins over any pull-up
  function automatic logic [W-1:0] resolve(input logic [W-1:0] pd,
                                           input logic [W-1:0] ext);
    return ~(pd | ext);
  endfunction

  assign pin = resolve(strong_pd, ext_low);

  qbd_port #(.WIDTH(W), .PULSE_CYCLES(TP)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_data_i(cmd_data), .rd_valid_i(rd_valid),
    .rd_ready_o(rd_ready), .rd_vld_o(rd_vld), .rd_data_o(rd_data), .pin_i(pin),
    .weak_pu_o(weak_pu), .strong_pu_o(strong_pu), .strong_pd_o(strong_pd)
  );

  // behavioural reference model
  logic [W-1:0] m_latch = '1;
  int m_cnt[W];
  logic m_rvld = 1'b0;
  logic [W-1:0] m_rdata = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_latch = '1;
      foreach (m_cnt[b]) m_cnt[b] = 0;
      m_rvld = 1'b0;
      m_rdata = '0;
    end else begin
      logic [W-1:0] nv;
      logic accept;
      accept = cmd_valid && cmd_op != 2'b11;
      nv = m_latch;
      if (cmd_op == 2'b00) nv = cmd_data;
      else if (cmd_op == 2'b01) nv = m_latch & cmd_data;
      else if (cmd_op == 2'b10) nv = m_latch | cmd_data;
      if (rd_valid) m_rdata = resolve(~m_latch, ext_low);
      m_rvld = rd_valid;
      for (int b = 0; b < W; b++) begin
        if (accept) m_cnt[b] = nv[b] ? TP : 0;
        else if (m_cnt[b] > 0) m_cnt[b] = m_cnt[b] - 1;
      end
      if (accept) m_latch = nv;
    end
  end

  function automatic logic [W-1:0] m_pu();
    logic [W-1:0] v;
    for (int b = 0; b < W; b++) v[b] = (m_cnt[b] > 0);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(strong_pd === ~m_latch, "R5 pull-down", strong_pd, ~m_latch);
      check(strong_pu === m_pu(), "R6 pulse", strong_pu, m_pu());
      check(weak_pu === '1, "R4 weak", weak_pu, '1);
      check((strong_pu & strong_pd) === '0, "R7 overlap", strong_pu & strong_pd, '0);
      check(rd_vld === m_rvld, "R9 rd_vld", W'(rd_vld), W'(m_rvld));
      if (m_rvld) check(rd_data === m_rdata, "R8 read", rd_data, m_rdata);
      check(cmd_ready === 1'b1 && rd_ready === 1'b1, "R9 ready",
            W'({cmd_ready, rd_ready}), W'(3));
    end
  end

  task automatic cmd(input logic [1:0] op, input logic [W-1:0] d);
    @(negedge clk);
    #0.5;
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    #0.5;
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd();
    @(negedge clk);
    #0.5;
    rd_valid = 1'b1;
    @(negedge clk);
    #0.5;
    rd_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state, seen during reset
    check(strong_pd === '0 && strong_pu === '0 && weak_pu === '1, "R1 reset",
          strong_pd | strong_pu, '0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    check(strong_pd === '0 && strong_pu === '0, "R1 after reset",
          strong_pd | strong_pu, '0);
    // R2 load and hold
    cmd(2'b00, 8'hA5);
    idle(10);
    check(strong_pd === 8'h5A, "R2 hold", strong_pd, 8'h5A);
    // R6 retrigger on bits already 1
    cmd(2'b00, 8'hFF);
    cmd(2'b00, 8'hF0);
    idle(5);
    // R3 AND / OR
    cmd(2'b01, 8'h3C);
    idle(4);
    check(strong_pd === ~8'h30, "R3 and", strong_pd, ~8'h30);
    cmd(2'b10, 8'h03);
    idle(4);
    check(strong_pd === ~8'h33, "R3 or", strong_pd, ~8'h33);
    // R3 reserved code ignored
    cmd(2'b11, 8'hCC);
    idle(1);
    check(strong_pd === ~8'h33 && strong_pu === '0, "R3 reserved",
          strong_pd, ~8'h33);
    // R8 read shows pins, not latch
    ext_low = 8'h02;
    rd();
    check(rd_data === 8'h31, "R8 pin read", rd_data, 8'h31);
    // R10 OR with zero keeps latched 1 on a pin held low
    cmd(2'b10, 8'h00);
    idle(1);
    check(strong_pd[1] === 1'b0, "R10 rmw latch", strong_pd, ~8'h33);
    rd();
    ext_low = '0;
    rd();
    check(rd_data === 8'h33, "R8 released", rd_data, 8'h33);
    // back-to-back and random traffic
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      #0.5;
      cmd_valid = $urandom_range(0, 2) == 0;
      cmd_op    = 2'($urandom_range(0, 3));
      cmd_data  = W'($urandom);
      rd_valid  = $urandom_range(0, 1) == 1;
      ext_low   = ($urandom_range(0, 3) == 0) ? W'($urandom) : '0;
    end
    @(negedge clk);
    #0.5;
    cmd_valid = 1'b0; rd_valid = 1'b0; ext_low = '0;
    idle(TP + 3);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule